// File: doc/BRIEF.md
# Randomized Gap Packet Dropper

A packet generator upstream of this block emits packets back to back, one per generation slot, with no pacing of its own. The block decides for every generated packet whether it is forwarded or dropped, and by doing so shapes the surviving stream so that its inter-packet times follow a distribution chosen in advance, for example an exponential one that makes the arrivals approximately Poisson. The time between two forwarded packets is always a whole number of generation slots.

Before a run, the gap values are written into a 256-entry table through a simple write port. Each value is the number of generated packets to discard after a forward. Whenever a packet is forwarded, a CRC-16 of the current 48-bit timestamp picks one table entry at random. The block loads that count into a pending-drop counter, and the packets that follow are discarded until the counter has run down to zero. An enable input gates the whole function. A packet budget stops forwarding once a configured number of packets has gone out. Two running counters report how many packets were forwarded and how many were dropped.

Top module: `rand_gap_dropper`

## Requirements
- R1: After reset `dec_valid` is 0, both counters read 0, every table entry holds 0 and no drops are pending, so the first packet seen while enabled is forwarded.
- R2: Every clock with `pkt_valid` high yields exactly one decision: `dec_valid` is high in the following cycle and only then, and `dec_fwd` there gives the decision (1 = forward, 0 = drop).
- R3: The table index is the low 8 bits of a CRC-16 of the timestamp sampled with the packet. The CRC uses polynomial 0x1021 and initial value 0xFFFF. Timestamp bit 47 enters first and no final XOR is applied.
- R4: A packet that is forwarded loads the pending-drop count with the table entry at its index. Each later packet seen while the count is nonzero is dropped and lowers the count by one. A packet seen at count zero is forwarded.
- R5: An entry of 0 makes the next generated packet forward as well, so a table of zeros forwards every packet back to back.
- R6: The gap is counted in packets, not clock cycles: idle cycles without `pkt_valid` leave the pending-drop count unchanged.
- R7: While `enable` is low, every packet is dropped and the pending-drop count is cleared. The first packet after enable returns is therefore forwarded, unless the budget stops it.
- R8: With a nonzero `budget`, once `fwd_count` has reached `budget`, every further packet is dropped and the pending-drop count is left unchanged. A `budget` of 0 means no limit.
- R9: `fwd_count` and `drop_count` each increase by one in the same cycle as a forward or drop decision respectively, and hold when no decision is made.
- R10: A table write with `tbl_we` high takes effect for lookups from the next clock onward. A lookup in the same cycle as a write to its own entry sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gates forwarding; low drops everything and clears pending drops |
| budget | input | 32 | Maximum number of forwarded packets, 0 = unlimited |
| tbl_we | input | 1 | Gap table write strobe |
| tbl_addr | input | 8 | Gap table write address |
| tbl_data | input | 16 | Gap count to store (in generation slots) |
| pkt_valid | input | 1 | One generated packet this cycle |
| timestamp | input | 48 | Current time, hashed to pick a table entry |
| dec_valid | output | 1 | Decision for the packet of the previous cycle |
| dec_fwd | output | 1 | 1 = forward, 0 = drop (valid with `dec_valid`) |
| fwd_count | output | 32 | Packets forwarded since reset |
| drop_count | output | 32 | Packets dropped since reset |

## Verification
A wrong pending-drop count, a miscomputed index or a stale table entry cannot stay hidden for long. Once the block leaves the fixed-rate regime, the next forward comes one or more packets early or late, and `dec_fwd` and both counters differ from the reference at the first decision that depends on it. The bench gives every packet a distinct timestamp, so the hash picks a different entry for almost every forward, and it compares the decision and both counters on every clock. An error in the hash or the table therefore shows up within one or two forward intervals. Idle cycles, enable drops, budget exhaustion and a write colliding with a lookup each leave the pending count in a state that the next few decisions expose.

// File: rtl/gd_pkg.sv
`timescale 1ns/1ps
package gd_pkg;
    localparam int          TS_W     = 48;
    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/gd_crc_hash.sv
`timescale 1ns/1ps
module gd_crc_hash
    import gd_pkg::*;
#(
    parameter int DATA_W = TS_W,
    parameter int IDX_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  idx
);
    // Bit-serial CRC unrolled over the whole word, most significant bit first.
    logic [CRC_W-1:0] crc_acc;
    logic             feedback;

    always_comb begin
        crc_acc  = CRC_INIT;
        feedback = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            feedback = crc_acc[CRC_W-1] ^ data[i];
            crc_acc  = {crc_acc[CRC_W-2:0], 1'b0};
            if (feedback) begin
                crc_acc = crc_acc ^ CRC_POLY;
            end
        end
        idx = crc_acc[IDX_W-1:0];
    end
endmodule

// File: rtl/gd_gap_table.sv
`timescale 1ns/1ps
module gd_gap_table #(
    parameter int IDX_W = 8,
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [GAP_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [GAP_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [GAP_W-1:0] mem_d [DEPTH];
    logic [GAP_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // Read sees registered contents: a same-cycle write is not visible yet.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/gd_drop_ctrl.sv
`timescale 1ns/1ps
module gd_drop_ctrl #(
    parameter int GAP_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] budget,
    input  logic             pkt_valid,
    input  logic [GAP_W-1:0] gap_value,
    output logic             dec_valid,
    output logic             dec_fwd,
    output logic [CNT_W-1:0] fwd_count,
    output logic [CNT_W-1:0] drop_count,
    output logic [GAP_W-1:0] gap_left
);
    typedef struct packed {
        logic             dv;
        logic             fwd;
        logic [GAP_W-1:0] gap;
        logic [CNT_W-1:0] nf;
        logic [CNT_W-1:0] nd;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     budget_hit;

    always_comb begin
        st_d       = st_q;
        st_d.dv    = pkt_valid;
        st_d.fwd   = 1'b0;
        budget_hit = (budget != '0) && (st_q.nf >= budget);
        if (pkt_valid) begin
            if (!enable || budget_hit) begin
                st_d.nd = st_q.nd + CNT_W'(1);
            end else if (st_q.gap != '0) begin
                st_d.gap = st_q.gap - GAP_W'(1);
                st_d.nd  = st_q.nd + CNT_W'(1);
            end else begin
                st_d.fwd = 1'b1;
                st_d.nf  = st_q.nf + CNT_W'(1);
                st_d.gap = gap_value;
            end
        end
        if (!enable) begin
            st_d.gap = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid  = st_q.dv;
    assign dec_fwd    = st_q.fwd;
    assign fwd_count  = st_q.nf;
    assign drop_count = st_q.nd;
    assign gap_left   = st_q.gap;
endmodule

// File: rtl/rand_gap_dropper.sv
`timescale 1ns/1ps
module rand_gap_dropper
    import gd_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int GAP_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] budget,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_addr,
    input  logic [GAP_W-1:0] tbl_data,
    input  logic             pkt_valid,
    input  logic [TS_W-1:0]  timestamp,
    output logic             dec_valid,
    output logic             dec_fwd,
    output logic [CNT_W-1:0] fwd_count,
    output logic [CNT_W-1:0] drop_count
);
    logic [IDX_W-1:0] pick_idx;
    logic [GAP_W-1:0] pick_gap;
    logic [GAP_W-1:0] gap_left;

    gd_crc_hash #(.DATA_W(TS_W), .IDX_W(IDX_W)) u_hash (
        .data (timestamp),
        .idx  (pick_idx)
    );

    gd_gap_table #(.IDX_W(IDX_W), .GAP_W(GAP_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (pick_idx),
        .rdata (pick_gap)
    );

    gd_drop_ctrl #(.GAP_W(GAP_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .budget     (budget),
        .pkt_valid  (pkt_valid),
        .gap_value  (pick_gap),
        .dec_valid  (dec_valid),
        .dec_fwd    (dec_fwd),
        .fwd_count  (fwd_count),
        .drop_count (drop_count),
        .gap_left   (gap_left)
    );
endmodule

// File: rtl/gd_chk.sv
`timescale 1ns/1ps
module gd_chk #(
    parameter int GAP_W = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] budget,
    input logic             pkt_valid,
    input logic             dec_valid,
    input logic             dec_fwd,
    input logic [CNT_W-1:0] fwd_count,
    input logic [CNT_W-1:0] drop_count,
    input logic [GAP_W-1:0] gap_left
);
    logic [CNT_W-1:0] total;
    assign total = fwd_count + drop_count;

    // R2
    dec_follows_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> dec_valid);

    // R2
    no_spurious_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !dec_valid);

    // R4
    pending_gap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && enable && gap_left != '0) |=> !dec_fwd);

    // R6
    idle_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && enable) |=> $stable(gap_left));

    // R7
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !enable) |=> (dec_valid && !dec_fwd));

    // R7
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gap_left == '0));

    // R8
    budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && budget != '0 && fwd_count >= budget) |=> !dec_fwd);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> (total == $past(total) + CNT_W'(1)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> ($stable(fwd_count) && $stable(drop_count)));
endmodule

bind rand_gap_dropper gd_chk #(.GAP_W(GAP_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .budget     (budget),
    .pkt_valid  (pkt_valid),
    .dec_valid  (dec_valid),
    .dec_fwd    (dec_fwd),
    .fwd_count  (fwd_count),
    .drop_count (drop_count),
    .gap_left   (gap_left)
);

// File: tb/sim_rand_gap_dropper.sv
`timescale 1ns/1ps
module sim_rand_gap_dropper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] budget = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        pkt_valid = 1'b0;
    logic [47:0] timestamp = '0;
    logic        dec_valid, dec_fwd;
    logic [31:0] fwd_count, drop_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase = "R1";

    // behavioural reference state
    int          m_tbl [256];
    int          m_gap = 0;
    int unsigned m_nf = 0, m_nd = 0;
    bit          m_dv = 0, m_fwd = 0;
    longint      now = 0;

    always #2.5 clk = ~clk;

    rand_gap_dropper u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .budget(budget),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .pkt_valid(pkt_valid), .timestamp(timestamp),
        .dec_valid(dec_valid), .dec_fwd(dec_fwd),
        .fwd_count(fwd_count), .drop_count(drop_count)
    );

    // R3: CRC-16, poly 0x1021, init 0xFFFF, bit 47 first, index = low byte
    function automatic int crc_index(input logic [47:0] ts);
        int c = 16'hFFFF;
        for (int i = 47; i >= 0; i--) begin
            int top = (c >> 15) & 1;
            c = (c << 1) & 16'hFFFF;
            if ((top ^ int'(ts[i])) != 0) c = c ^ 16'h1021;
        end
        return c & 8'hFF;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [47:0] mk_ts();
        return 48'(now * 64'h9E3779B97F4A7C15 + now);
    endfunction

    // One clock: apply inputs, advance the model, compare after the edge.
    task automatic tick(input bit pv, input bit we = 0, input int wa = 0, input int wd = 0);
        logic [47:0] ts = mk_ts();
        pkt_valid = pv; timestamp = ts;
        tbl_we = we; tbl_addr = 8'(wa); tbl_data = 16'(wd);
        m_dv = pv; m_fwd = 0;
        if (pv) begin
            if (!enable || (budget != 0 && m_nf >= budget)) m_nd++;
            else if (m_gap != 0) begin m_gap--; m_nd++; end
            else begin m_fwd = 1; m_nf++; m_gap = m_tbl[crc_index(ts)]; end
        end
        if (!enable) m_gap = 0;
        if (we) m_tbl[wa] = wd;
        now++;
        @(posedge clk); #1;
        check("R2 dec_valid", dec_valid, m_dv);
        if (m_dv) check({phase, " dec_fwd"}, dec_fwd, m_fwd);
        check({"R9 fwd_count ", phase}, fwd_count, m_nf);
        check({"R9 drop_count ", phase}, drop_count, m_nd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_tbl[i] = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1 dec_valid", dec_valid, 0);
        check("R1 fwd_count", fwd_count, 0);
        check("R1 drop_count", drop_count, 0);
        enable = 1'b1;
        phase = "R1";
        tick(1); tick(1);                   // zero table: both forwarded

        // R10: load table while idle
        phase = "R10";
        for (int i = 0; i < 256; i++) tick(0, 1, i, (i * 7) % 6);

        // R3/R4: back-to-back generation with varied timestamps
        phase = "R4";
        for (int i = 0; i < 300; i++) tick(1);

        // R6: packets interleaved with idle cycles
        phase = "R6";
        for (int i = 0; i < 200; i++) tick(((i * 5) % 3) != 0);

        // R7: disable mid-run, then resume
        phase = "R7";
        tick(1); tick(1);
        enable = 1'b0;
        for (int i = 0; i < 20; i++) tick((i % 4) != 1);
        enable = 1'b1;
        tick(1); tick(1); tick(1);

        // R5: all-zero table forwards every packet
        phase = "R5";
        for (int i = 0; i < 256; i++) tick(0, 1, i, 0);
        for (int i = 0; i < 50; i++) tick(1);

        // R10: write the entry being looked up in the same cycle
        phase = "R10";
        begin
            int hit_idx = crc_index(mk_ts());
            tick(1, 1, hit_idx, 3);         // uses old value 0
        end
        tick(1);                            // forwarded again, old value seen
        for (int i = 0; i < 10; i++) tick(1);

        // R8: budget limit, then unlimited
        phase = "R8";
        for (int i = 0; i < 256; i++) tick(0, 1, i, (i * 3) % 4);
        budget = m_nf + 15;
        for (int i = 0; i < 200; i++) tick(1);
        check("R8 capped fwd_count", fwd_count, budget);
        budget = '0;
        for (int i = 0; i < 40; i++) tick(1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule